// File: doc/BRIEF.md
# Eight-bit accumulator processor core

This block is a small multi-cycle processor with one accumulator. It carries its own 32-byte memory, which holds both instructions and data. It keeps a program counter, an instruction register, a memory address register, a memory data register and an 8-bit accumulator. A control sequencer moves each instruction through a fixed series of one-clock register transfers. Every memory access goes through the address and data registers, and each read or write takes one clock of its own.

Each instruction word holds an operation code in its top three bits and a memory address in its low five bits. After reset the core takes its first instruction from the address on `start_addr`. It runs until it meets a halt instruction, then raises `halted` and stays frozen until the next reset. A side port lets a test environment preload memory words and read them back. Results become visible when a program stores the accumulator to memory.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low, `halted` is 0. The first clock after reset is released copies `start_addr` into the program counter, and the first instruction is fetched from that address. A reset applied while halted clears `halted`.
- R2: An instruction word holds its operation code in bits [7:5] and its operand address in bits [4:0]. The codes are: 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 branch, 6 branch if accumulator is zero, 7 branch if accumulator is positive. Every fetch copies PC to MAR, reads memory into MDR, then copies MDR into IR.
- R3: Load places the byte at the operand address into the accumulator.
- R4: Add places accumulator plus operand, modulo 256, into the accumulator. For example, 0x05 plus 0xFD gives 0x02.
- R5: Subtract places accumulator minus operand, modulo 256, into the accumulator. For example, 0x00 minus 0x01 gives 0xFF.
- R6: Store writes the accumulator to the operand address and leaves the accumulator unchanged.
- R7: Branch always loads the program counter from the operand address.
- R8: Branch-if-zero jumps only when the accumulator is 0x00. Otherwise execution continues at the next address.
- R9: Branch-if-positive jumps only when accumulator bit 7 is 0 and the accumulator is nonzero. Otherwise execution continues at the next address.
- R10: Halt raises `halted`. The core then holds its program counter and performs no memory write until reset.
- R11: Timing in clocks: the start after reset takes 1, load, add, subtract and store take 7 each, a branch (taken or not) takes 4, and a halt takes 4 from the start of its fetch until `halted` reads 1.
- R12: When `dbg_we` is high, a clock edge writes `dbg_wdata` to memory at `dbg_addr`. This write wins over a core write in the same cycle. `dbg_rdata` always shows, combinationally, the byte at `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_addr | input | 5 | First instruction address, taken in the first clock after reset |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_we | input | 1 | Side-port memory write enable |
| dbg_addr | input | 5 | Side-port memory address |
| dbg_wdata | input | 8 | Side-port write data |
| dbg_rdata | output | 8 | Side-port read data |

## Verification
Some properties are checked on every cycle:
- the fetch copies the program counter into MAR;
- a load writes MDR into the accumulator;
- store data equals the accumulator at the moment of the write;
- a negative accumulator never makes branch-if-positive jump;
- the start address enters the program counter;
- once halted, the core stays halted, keeps its PC and does no writes.

Other behaviour shows only through the bench's programs and the memory they leave behind:
- the arithmetic results and their wraparound at 256;
- the zero and sign boundaries of the conditional branches, and which path is taken;
- the exact clock count of each instruction class;
- starting from a nonzero address.

// File: rtl/acc8_core_pkg.sv
package acc8_core_pkg;

  typedef enum logic [2:0] {
    OP_HLT = 3'd0,
    OP_LDA = 3'd1,
    OP_STA = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4,
    OP_BR  = 3'd5,
    OP_BRZ = 3'd6,
    OP_BRP = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    PH_BOOT,
    PH_FADDR,
    PH_FREAD,
    PH_FLATCH,
    PH_DECODE,
    PH_OREAD,
    PH_EXEC,
    PH_ADVANCE,
    PH_SADDR,
    PH_SWRITE,
    PH_STOP
  } phase_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_e;

  typedef struct packed {
    logic    pc_from_start;
    logic    pc_from_ir;
    logic    pc_step;
    logic    mar_from_pc;
    logic    mar_from_ir;
    logic    mdr_from_mem;
    logic    mdr_from_acc;
    logic    ir_load;
    logic    acc_load;
    logic    mem_we;
    alu_op_e alu_op;
  } ctrl_s;

endpackage

// File: rtl/acc8_core_mem.sv
module acc8_core_mem #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] core_addr,
  input  logic          core_we,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  // side port wins when both write in one cycle
  always_ff @(posedge clk) begin
    if (dbg_we) begin
      store_q[dbg_addr] <= dbg_wdata;
    end else if (core_we) begin
      store_q[core_addr] <= core_wdata;
    end
  end

  assign core_rdata = store_q[core_addr];
  assign dbg_rdata  = store_q[dbg_addr];

endmodule

// File: rtl/acc8_core_alu.sv
module acc8_core_alu
  import acc8_core_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] result,
  output logic          acc_zero,
  output logic          acc_pos
);

  always_comb begin
    unique case (op)
      ALU_ADD: result = acc + opnd;
      ALU_SUB: result = acc - opnd;
      default: result = opnd;
    endcase
  end

  assign acc_zero = (acc == '0);
  assign acc_pos  = !acc[DW-1] && !acc_zero;

endmodule

// File: rtl/acc8_core_seq.sv
module acc8_core_seq
  import acc8_core_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e opcode,
  input  logic    acc_zero,
  input  logic    acc_pos,
  output phase_e  phase_q,
  output ctrl_s   ctrl
);

  phase_e phase_d;
  logic   jump_ok;

  always_comb begin
    unique case (opcode)
      OP_BR:   jump_ok = 1'b1;
      OP_BRZ:  jump_ok = acc_zero;
      OP_BRP:  jump_ok = acc_pos;
      default: jump_ok = 1'b0;
    endcase
  end

  // next phase
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_BOOT:    phase_d = PH_FADDR;
      PH_FADDR:   phase_d = PH_FREAD;
      PH_FREAD:   phase_d = PH_FLATCH;
      PH_FLATCH:  phase_d = PH_DECODE;
      PH_DECODE: begin
        unique case (opcode)
          OP_HLT:                 phase_d = PH_STOP;
          OP_LDA, OP_ADD, OP_SUB: phase_d = PH_OREAD;
          OP_STA:                 phase_d = PH_SADDR;
          default:                phase_d = PH_FADDR;
        endcase
      end
      PH_OREAD:   phase_d = PH_EXEC;
      PH_EXEC:    phase_d = PH_ADVANCE;
      PH_ADVANCE: phase_d = PH_FADDR;
      PH_SADDR:   phase_d = PH_SWRITE;
      PH_SWRITE:  phase_d = PH_ADVANCE;
      PH_STOP:    phase_d = PH_STOP;
      default:    phase_d = PH_BOOT;
    endcase
  end

  // register transfer strobes
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_PASS;
    unique case (phase_q)
      PH_BOOT:    ctrl.pc_from_start = 1'b1;
      PH_FADDR:   ctrl.mar_from_pc   = 1'b1;
      PH_FREAD:   ctrl.mdr_from_mem  = 1'b1;
      PH_FLATCH:  ctrl.ir_load       = 1'b1;
      PH_DECODE: begin
        unique case (opcode)
          OP_LDA, OP_ADD, OP_SUB: ctrl.mar_from_ir  = 1'b1;
          OP_STA:                 ctrl.mdr_from_acc = 1'b1;
          OP_BR, OP_BRZ, OP_BRP: begin
            ctrl.pc_from_ir = jump_ok;
            ctrl.pc_step    = !jump_ok;
          end
          default: ;
        endcase
      end
      PH_OREAD:   ctrl.mdr_from_mem = 1'b1;
      PH_EXEC: begin
        ctrl.acc_load = 1'b1;
        unique case (opcode)
          OP_ADD:  ctrl.alu_op = ALU_ADD;
          OP_SUB:  ctrl.alu_op = ALU_SUB;
          default: ctrl.alu_op = ALU_PASS;
        endcase
      end
      PH_ADVANCE: ctrl.pc_step     = 1'b1;
      PH_SADDR:   ctrl.mar_from_ir = 1'b1;
      PH_SWRITE:  ctrl.mem_we      = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_BOOT;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_core_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  output logic          halted,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata
);
  localparam int OPW = DW - AW;

  logic [AW-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DW-1:0] mdr_q, mdr_d, ir_q, acc_q, alu_res, mem_rdata;
  logic          pc_en, mar_en, mdr_en;
  logic          acc_zero, acc_pos;
  phase_e        phase_q;
  ctrl_s         ctrl;
  opcode_e       opcode;
  logic [AW-1:0] ir_addr;

  assign opcode  = opcode_e'(ir_q[DW-1 -: OPW]);
  assign ir_addr = ir_q[AW-1:0];

  acc8_core_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .acc_zero (acc_zero),
    .acc_pos  (acc_pos),
    .phase_q  (phase_q),
    .ctrl     (ctrl)
  );

  acc8_core_alu #(.DW(DW)) alu_i (
    .op       (ctrl.alu_op),
    .acc      (acc_q),
    .opnd     (mdr_q),
    .result   (alu_res),
    .acc_zero (acc_zero),
    .acc_pos  (acc_pos)
  );

  acc8_core_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk        (clk),
    .core_addr  (mar_q),
    .core_we    (ctrl.mem_we),
    .core_wdata (mdr_q),
    .core_rdata (mem_rdata),
    .dbg_we     (dbg_we),
    .dbg_addr   (dbg_addr),
    .dbg_wdata  (dbg_wdata),
    .dbg_rdata  (dbg_rdata)
  );

  // next values
  always_comb begin
    pc_en = ctrl.pc_from_start | ctrl.pc_from_ir | ctrl.pc_step;
    if (ctrl.pc_from_start)   pc_d = start_addr;
    else if (ctrl.pc_from_ir) pc_d = ir_addr;
    else                      pc_d = pc_q + 1'b1;

    mar_en = ctrl.mar_from_pc | ctrl.mar_from_ir;
    mar_d  = ctrl.mar_from_pc ? pc_q : ir_addr;

    mdr_en = ctrl.mdr_from_mem | ctrl.mdr_from_acc;
    mdr_d  = ctrl.mdr_from_acc ? acc_q : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (pc_en)         pc_q  <= pc_d;
      if (mar_en)        mar_q <= mar_d;
      if (mdr_en)        mdr_q <= mdr_d;
      if (ctrl.ir_load)  ir_q  <= mdr_q;
      if (ctrl.acc_load) acc_q <= alu_res;
    end
  end

  assign halted = (phase_q == PH_STOP);

endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk
  import acc8_core_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halted,
  input logic [AW-1:0] start_addr,
  input phase_e        phase_q,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] mar_q,
  input logic [DW-1:0] mdr_q,
  input logic [DW-1:0] ir_q,
  input logic [DW-1:0] acc_q,
  input logic          mem_we
);

  // R1
  boot_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BOOT) |=> (pc_q == $past(start_addr)));

  // R2
  fetch_mar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FADDR) |=> (mar_q == $past(pc_q)));

  // R3
  load_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC && ir_q[DW-1:AW] == OP_LDA) |=> (acc_q == $past(mdr_q)));

  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mdr_q == acc_q && mar_q == ir_q[AW-1:0]));

  // R9
  brp_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DECODE && ir_q[DW-1:AW] == OP_BRP && acc_q[DW-1])
      |=> (pc_q == AW'($past(pc_q) + 1'b1)));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc_q) && !mem_we));

  // R11
  advance_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADVANCE) |=> (phase_q == PH_FADDR));

endmodule

bind acc8_core acc8_core_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .halted     (halted),
  .start_addr (start_addr),
  .phase_q    (phase_q),
  .pc_q       (pc_q),
  .mar_q      (mar_q),
  .mdr_q      (mdr_q),
  .ir_q       (ir_q),
  .acc_q      (acc_q),
  .mem_we     (ctrl.mem_we)
);

// File: tb/acc8_core_tb_top.sv
module acc8_core_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 13;
  // {op[26:24], a[23:16], b[15:8], expected mem[22][7:0]}
  localparam logic [26:0] VEC [NV] = '{
    {3'd1, 8'h33, 8'h9C, 8'h9C},  // R3 load
    {3'd3, 8'h05, 8'hFD, 8'h02},  // R4 add wraps
    {3'd3, 8'h7F, 8'h01, 8'h80},  // R4
    {3'd4, 8'h05, 8'h03, 8'h02},  // R5 sub
    {3'd4, 8'h00, 8'h01, 8'hFF},  // R5 borrow wraps
    {3'd2, 8'h5A, 8'h00, 8'h5A},  // R6 store
    {3'd5, 8'h80, 8'h00, 8'h22},  // R7 branch
    {3'd6, 8'h00, 8'h00, 8'h22},  // R8 zero taken
    {3'd6, 8'h01, 8'h00, 8'h11},  // R8 not taken
    {3'd7, 8'h01, 8'h00, 8'h22},  // R9 taken
    {3'd7, 8'h80, 8'h00, 8'h11},  // R9 negative
    {3'd7, 8'h00, 8'h00, 8'h11},  // R9 zero
    {3'd0, 8'h44, 8'h00, 8'h00}   // R10 halt at word 1
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] start_addr;
  logic       halted;
  logic       dbg_we;
  logic [4:0] dbg_addr;
  logic [7:0] dbg_wdata;
  logic [7:0] dbg_rdata;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  acc8_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_addr (start_addr),
    .halted     (halted),
    .dbg_we     (dbg_we),
    .dbg_addr   (dbg_addr),
    .dbg_wdata  (dbg_wdata),
    .dbg_rdata  (dbg_rdata)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic mem_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    dbg_addr = a;
    #1 d = dbg_rdata;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) mem_wr(5'(i), 8'h00);
  endtask

  task automatic release_and_run(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_cycles(input logic [2:0] op);
    if (op == 3'd0)  return 12;
    if (op >= 3'd5)  return 30;
    return 26;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int cyc;
    rst_n = 1'b0; start_addr = 5'd0;
    dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 halted low in reset", int'(halted), 0);

    // R12 side port write and combinational read
    mem_wr(5'd30, 8'hC3);
    mem_rd(5'd30, rd);
    chk("R12 side port readback", int'(rd), 8'hC3);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      logic [7:0] a, b, e;
      {op, a, b, e} = VEC[v];
      rst_n = 1'b0;
      clear_mem();
      mem_wr(5'd0, 8'h34);            // load 20
      if (op >= 3'd5) begin
        mem_wr(5'd1, {op, 5'd5});
        mem_wr(5'd2, 8'h37);          // load 23
        mem_wr(5'd3, 8'h56);          // store 22
        mem_wr(5'd5, 8'h38);          // load 24
        mem_wr(5'd6, 8'h56);
      end else begin
        mem_wr(5'd1, {op, 5'd21});
        mem_wr(5'd2, 8'h56);
      end
      mem_wr(5'd20, a);
      mem_wr(5'd21, b);
      mem_wr(5'd23, 8'h11);
      mem_wr(5'd24, 8'h22);
      release_and_run(cyc);
      mem_rd(5'd22, rd);
      case (op)
        3'd1: chk("R3 load result", int'(rd), int'(e));
        3'd2: chk("R6 store result", int'(rd), int'(e));
        3'd3: chk("R4 add result", int'(rd), int'(e));
        3'd4: chk("R5 sub result", int'(rd), int'(e));
        3'd5: chk("R7 branch path", int'(rd), int'(e));
        3'd6: chk("R8 zero-branch path", int'(rd), int'(e));
        3'd7: chk("R9 positive-branch path", int'(rd), int'(e));
        default: chk("R10 halt stops before store", int'(rd), int'(e));
      endcase
      chk("R11 clocks to halted", cyc, exp_cycles(op));
    end

    // R2 encodings: store to a chosen address via field [4:0]
    rst_n = 1'b0;
    clear_mem();
    mem_wr(5'd0, 8'h34);
    mem_wr(5'd1, 8'h5F);              // store 31
    mem_wr(5'd20, 8'hA7);
    release_and_run(cyc);
    mem_rd(5'd31, rd);
    chk("R2 address field selects word 31", int'(rd), 8'hA7);

    // R1 start address: program at 10, decoy at 0
    rst_n = 1'b0;
    start_addr = 5'd10;
    clear_mem();
    mem_wr(5'd0, 8'h37);
    mem_wr(5'd1, 8'h56);
    mem_wr(5'd10, 8'h34);
    mem_wr(5'd11, 8'h75);             // add 21
    mem_wr(5'd12, 8'h56);
    mem_wr(5'd20, 8'h01);
    mem_wr(5'd21, 8'h02);
    mem_wr(5'd23, 8'h11);
    release_and_run(cyc);
    mem_rd(5'd22, rd);
    chk("R1 runs from start address", int'(rd), 8'h03);
    chk("R11 clocks from start address", cyc, 26);

    // R10 halted persists and nothing changes
    repeat (20) @(negedge clk);
    chk("R10 halted holds", int'(halted), 1);
    mem_rd(5'd22, rd);
    chk("R10 memory untouched after halt", int'(rd), 8'h03);
    mem_rd(5'd21, rd);
    chk("R10 operand untouched after halt", int'(rd), 8'h02);

    // R1 reset from halted state
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 reset clears halted", int'(halted), 0);

    // R12 side port write wins and reads back while core is running
    start_addr = 5'd0;
    clear_mem();
    mem_wr(5'd0, 8'hA0);              // branch to 0: spin forever
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    mem_wr(5'd25, 8'h6E);
    mem_rd(5'd25, rd);
    chk("R12 side write during run", int'(rd), 8'h6E);
    chk("R7 spin loop never halts", int'(halted), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule